// File: doc/BRIEF.md
# Chained DMA Channel Sequencer

This block is the control core of one DMA channel that moves data between a local bus and a PCI-side bus. Software programs a configuration word, a byte count and a 64-bit chain pointer through a small register port. The channel then issues a series of word-level transaction requests of the selected size and counts the remaining bytes down to zero. When chaining is on, it pulls the next descriptor through a separate read port. Each descriptor is four 64-bit words: source address, destination address, byte count and next pointer.

Both buses and the descriptor memory are reduced to request/acknowledge pairs. The channel holds a request until it is acknowledged. It also passes a data word through a byte-order stage that can reverse the bytes inside each 32-bit lane. An abort input stands in for bus errors. A one-cycle interrupt pulse marks the end of each transfer.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset the configuration register (select 0) reads 0x001 and the count (select 1), chain low (select 2), chain high (select 3) and status (select 4) registers read 0. Configuration bits are: 8 interrupt enable, 7 direction, 6 chain enable (read-only), 5 active, 4 reads 0, 3:2 size, 1 swap, 0 channel reset. Status bit 0 is abnormal end and bit 1 is chain end.
- R2: While channel reset is 1, writes to active, count, chain and status are ignored. Setting channel reset clears count, chain pointer, addresses, status, active and chain enable.
- R3: The size field sets the bytes per transaction: 00 gives 4, 01 gives 8, 10 gives 32, and the reserved 11 gives 4, reported on xfer_size as 00. Each accepted transaction lowers the count by that amount, stopping at zero, and advances both addresses by the same amount.
- R4: xfer_dir follows the direction bit. When swap is 1, dat_out is dat_in with the four bytes of every 32-bit lane reversed; otherwise dat_out equals dat_in.
- R5: Writing active = 1 has no effect when the count is 0 and chain enable is 0.
- R6: With a nonzero count, setting active makes xfer_req stay high until the count reaches zero. Active then clears.
- R7: When the final transaction of a transfer is accepted with interrupt enable set, irq pulses for exactly one cycle. With interrupt enable clear, there is no pulse.
- R8: A nonzero write to chain low sets chain enable and active, and the channel starts with a descriptor fetch at the chain pointer. A zero write to chain low clears chain enable. Writes to chain high change neither flag.
- R9: A fetch reads four words at pointer +0, +8, +16 and +24 into source, destination, count and next pointer. Chain enable becomes (next[31:0] != 0). After that transfer completes, the channel fetches again if chain enable is still set.
- R10: A descriptor whose next pointer has zero low bits sets status bit 1. Writing 1 to that bit clears it.
- R11: Abort clears active, drops both request lines on the next cycle and sets status bit 0. Writing 1 to that bit clears it.
- R12: Clearing active during a transfer lets the outstanding transaction finish, then the channel stops with the remaining count kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| abort | input | 1 | Error abort |
| xfer_req | output | 1 | Transaction request |
| xfer_ack | input | 1 | Transaction accepted |
| xfer_size | output | 2 | Transaction size code |
| xfer_dir | output | 1 | 1: local to PCI side, 0: PCI side to local |
| xfer_src | output | 64 | Current source address |
| xfer_dst | output | 64 | Current destination address |
| dat_in | input | LANES*32 | Data word entering the byte-order stage |
| dat_out | output | LANES*32 | Data word after optional swap |
| desc_req | output | 1 | Descriptor word request |
| desc_ack | input | 1 | Descriptor word valid |
| desc_addr | output | 64 | Descriptor word address |
| desc_data | input | 64 | Descriptor word |
| irq | output | 1 | Completion pulse |

## Verification
The bench builds the channel with a 12-bit count and two 32-bit data lanes. The narrow count keeps the wide-count corner, a count that is not a multiple of the transaction size, reachable with small values: 6 bytes at the 4-byte size takes two transactions and then stops at zero. The two lanes show that the swap stays inside each 32-bit lane and never crosses between lanes. A two-descriptor chain drives the refetch path and the chain-end flag with short runs.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FETCH} seq_st_e;

  localparam logic [2:0] SEL_CFG  = 3'd0;
  localparam logic [2:0] SEL_CNT  = 3'd1;
  localparam logic [2:0] SEL_CHLO = 3'd2;
  localparam logic [2:0] SEL_CHHI = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  function automatic logic [5:0] beat_bytes(input logic [1:0] sz);
    case (sz)
      2'b01:   beat_bytes = 6'd8;
      2'b10:   beat_bytes = 6'd32;
      default: beat_bytes = 6'd4;
    endcase
  endfunction

  function automatic logic [1:0] eff_size(input logic [1:0] sz);
    eff_size = (sz == 2'b11) ? 2'b00 : sz;
  endfunction
endpackage

// File: rtl/dma_swap.sv
module dma_swap #(
  parameter int LANES = 2
) (
  input  logic [LANES*32-1:0] din,
  input  logic                swap,
  output logic [LANES*32-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [31:0] w;
    assign w = din[g*32 +: 32];
    assign dout[g*32 +: 32] = swap ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chain_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [2:0]  sel,
  input  logic [31:0] wd,
  input  logic        abort,
  input  logic        beat,
  input  logic        dload_we,
  input  logic [1:0]  dload_idx,
  input  logic [63:0] dload_data,
  input  logic        fetch_go,
  input  logic        act_clr,
  output logic [31:0] rdata,
  output logic        crst,
  output logic        ie,
  output logic        dir,
  output logic [1:0]  size,
  output logic        swap,
  output logic        act,
  output logic        chen,
  output logic        ff,
  output logic        cnt_nz,
  output logic        cnt_last,
  output logic [63:0] src,
  output logic [63:0] dst,
  output logic [63:0] chain
);
  logic crst_q, ie_q, dir_q, swap_q, act_q, chen_q, ff_q, abn_q, ncc_q;
  logic crst_d, ie_d, dir_d, swap_d, act_d, chen_d, ff_d, abn_d, ncc_d;
  logic [1:0] size_q, size_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, bb_w;
  logic [63:0] src_q, src_d, dst_q, dst_d, chain_q, chain_d;
  logic wr_cfg, wr_cnt, wr_lo, wr_hi, wr_st;

  assign bb_w   = CNT_W'(beat_bytes(size_q));
  assign wr_cfg = we && sel == SEL_CFG;
  assign wr_cnt = we && sel == SEL_CNT  && !crst_q;
  assign wr_lo  = we && sel == SEL_CHLO && !crst_q;
  assign wr_hi  = we && sel == SEL_CHHI && !crst_q;
  assign wr_st  = we && sel == SEL_STAT && !crst_q;

  always_comb begin
    crst_d = crst_q; ie_d = ie_q; dir_d = dir_q; swap_d = swap_q; size_d = size_q;
    act_d = act_q; chen_d = chen_q; ff_d = ff_q; abn_d = abn_q; ncc_d = ncc_q;
    cnt_d = cnt_q; src_d = src_q; dst_d = dst_q; chain_d = chain_q;
    if (wr_cfg) begin
      ie_d = wd[8]; dir_d = wd[7]; size_d = wd[3:2]; swap_d = wd[1]; crst_d = wd[0];
      if (!wd[5]) act_d = 1'b0;
      else if (cnt_q != '0 || chen_q) act_d = 1'b1;
    end
    if (wr_lo) begin
      chain_d[31:0] = wd;
      chen_d = (wd != 32'd0);
      if (wd != 32'd0) act_d = 1'b1;
    end
    if (wr_hi) chain_d[63:32] = wd;
    if (act_clr || abort) act_d = 1'b0;
    if (fetch_go) ff_d = 1'b0;
    if (wr_lo && wd != 32'd0) ff_d = 1'b1;
    if (wr_cnt) cnt_d = wd[CNT_W-1:0];
    if (wr_st && wd[0]) abn_d = 1'b0;
    if (wr_st && wd[1]) ncc_d = 1'b0;
    if (abort) abn_d = 1'b1;
    if (dload_we) begin
      case (dload_idx)
        2'd0: src_d = dload_data;
        2'd1: dst_d = dload_data;
        2'd2: cnt_d = dload_data[CNT_W-1:0];
        default: begin
          chain_d = dload_data;
          chen_d  = (dload_data[31:0] != 32'd0);
          if (dload_data[31:0] == 32'd0) ncc_d = 1'b1;
        end
      endcase
    end
    if (beat) begin
      cnt_d = (cnt_q <= bb_w) ? '0 : cnt_q - bb_w;
      src_d = src_q + 64'(beat_bytes(size_q));
      dst_d = dst_q + 64'(beat_bytes(size_q));
    end
    if (crst_q) begin
      act_d = 1'b0; chen_d = 1'b0; ff_d = 1'b0; abn_d = 1'b0; ncc_d = 1'b0;
      cnt_d = '0; src_d = '0; dst_d = '0; chain_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crst_q <= 1'b1; ie_q <= 1'b0; dir_q <= 1'b0; swap_q <= 1'b0; size_q <= 2'b00;
      act_q <= 1'b0; chen_q <= 1'b0; ff_q <= 1'b0; abn_q <= 1'b0; ncc_q <= 1'b0;
      cnt_q <= '0; src_q <= '0; dst_q <= '0; chain_q <= '0;
    end else begin
      crst_q <= crst_d; ie_q <= ie_d; dir_q <= dir_d; swap_q <= swap_d; size_q <= size_d;
      act_q <= act_d; chen_q <= chen_d; ff_q <= ff_d; abn_q <= abn_d; ncc_q <= ncc_d;
      cnt_q <= cnt_d; src_q <= src_d; dst_q <= dst_d; chain_q <= chain_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_CFG:  rdata = {23'd0, ie_q, dir_q, chen_q, act_q, 1'b0, size_q, swap_q, crst_q};
      SEL_CNT:  rdata = 32'(cnt_q);
      SEL_CHLO: rdata = chain_q[31:0];
      SEL_CHHI: rdata = chain_q[63:32];
      SEL_STAT: rdata = {30'd0, ncc_q, abn_q};
      default:  rdata = 32'd0;
    endcase
  end

  assign crst = crst_q; assign ie = ie_q; assign dir = dir_q; assign size = size_q;
  assign swap = swap_q; assign act = act_q; assign chen = chen_q; assign ff = ff_q;
  assign cnt_nz = (cnt_q != '0); assign cnt_last = (cnt_q <= bb_w);
  assign src = src_q; assign dst = dst_q; assign chain = chain_q;

  // R5: active rises only with work pending or on a chain-low write
  a_r5_start_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(cnt_q != '0 || chen_q || (we && sel == SEL_CHLO)));
  // R8: chain enable rises only from a chain-low write or a next-pointer load
  a_r8_chen_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chen_q) |-> ($past(we && sel == SEL_CHLO) || $past(dload_we && dload_idx == 2'd3)));
  // R11: abort outside reset leaves the abnormal flag set and active clear
  a_r11_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !crst_q) |=> (abn_q && !act_q));
  // R3: an accepted transaction never raises the count
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chain_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        crst,
  input  logic        act,
  input  logic        chen,
  input  logic        ff,
  input  logic        ie,
  input  logic        cnt_nz,
  input  logic        cnt_last,
  input  logic [63:0] chain,
  input  logic        abort,
  input  logic        xfer_ack,
  input  logic        desc_ack,
  output logic        xfer_req,
  output logic        desc_req,
  output logic [63:0] desc_addr,
  output logic        beat,
  output logic        dload_we,
  output logic [1:0]  dload_idx,
  output logic        fetch_go,
  output logic        act_clr,
  output logic        irq
);
  seq_st_e st_q, st_d;
  logic [1:0] idx_q, idx_d;
  logic irq_q, irq_d;

  assign xfer_req  = (st_q == ST_XFER);
  assign desc_req  = (st_q == ST_FETCH);
  assign desc_addr = chain + {59'd0, idx_q, 3'd0};
  assign dload_idx = idx_q;
  assign irq       = irq_q;

  always_comb begin
    st_d = st_q; idx_d = idx_q; irq_d = 1'b0;
    beat = 1'b0; dload_we = 1'b0; fetch_go = 1'b0; act_clr = 1'b0;
    case (st_q)
      ST_IDLE: if (act) begin
        if (ff || (!cnt_nz && chen)) begin
          st_d = ST_FETCH; idx_d = 2'd0; fetch_go = 1'b1;
        end else if (cnt_nz) st_d = ST_XFER;
        else act_clr = 1'b1;
      end
      ST_XFER: if (xfer_ack) begin
        beat = 1'b1;
        if (cnt_last) begin
          irq_d = ie;
          if (chen && act) begin
            st_d = ST_FETCH; idx_d = 2'd0; fetch_go = 1'b1;
          end else begin
            st_d = ST_IDLE; act_clr = 1'b1;
          end
        end else if (!act) st_d = ST_IDLE;
      end
      ST_FETCH: if (desc_ack) begin
        dload_we = 1'b1;
        idx_d = idx_q + 2'd1;
        if (idx_q == 2'd3) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (abort || crst) begin
      st_d = ST_IDLE; idx_d = 2'd0; irq_d = 1'b0;
      beat = 1'b0; dload_we = 1'b0; fetch_go = 1'b0; act_clr = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= 2'd0; irq_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; irq_q <= irq_d;
    end
  end

  // R7: an interrupt pulse follows an accepted transaction
  a_r7_irq_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(xfer_req && xfer_ack));
  // R9: a descriptor request stays up until it is served
  a_r9_desc_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && !desc_ack && !abort && !crst) |=> desc_req);
  // R11: abort drops both request lines
  a_r11_abort_drops: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!xfer_req && !desc_req));
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LANES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [2:0]          reg_sel,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                abort,
  output logic                xfer_req,
  input  logic                xfer_ack,
  output logic [1:0]          xfer_size,
  output logic                xfer_dir,
  output logic [63:0]         xfer_src,
  output logic [63:0]         xfer_dst,
  input  logic [LANES*32-1:0] dat_in,
  output logic [LANES*32-1:0] dat_out,
  output logic                desc_req,
  input  logic                desc_ack,
  output logic [63:0]         desc_addr,
  input  logic [63:0]         desc_data,
  output logic                irq
);
  logic [1:0] rs_q;
  logic rst_s;
  logic crst, ie, dir, swap, act, chen, ff, cnt_nz, cnt_last;
  logic beat, dload_we, fetch_go, act_clr;
  logic [1:0] size, dload_idx;
  logic [63:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  dma_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .we(reg_we), .sel(reg_sel), .wd(reg_wdata), .abort(abort),
    .beat(beat), .dload_we(dload_we), .dload_idx(dload_idx), .dload_data(desc_data),
    .fetch_go(fetch_go), .act_clr(act_clr), .rdata(reg_rdata), .crst(crst), .ie(ie),
    .dir(dir), .size(size), .swap(swap), .act(act), .chen(chen), .ff(ff),
    .cnt_nz(cnt_nz), .cnt_last(cnt_last), .src(xfer_src), .dst(xfer_dst), .chain(chain)
  );

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_s), .crst(crst), .act(act), .chen(chen), .ff(ff), .ie(ie),
    .cnt_nz(cnt_nz), .cnt_last(cnt_last), .chain(chain), .abort(abort),
    .xfer_ack(xfer_ack), .desc_ack(desc_ack), .xfer_req(xfer_req), .desc_req(desc_req),
    .desc_addr(desc_addr), .beat(beat), .dload_we(dload_we), .dload_idx(dload_idx),
    .fetch_go(fetch_go), .act_clr(act_clr), .irq(irq)
  );

  dma_swap #(.LANES(LANES)) u_swap (.din(dat_in), .swap(swap), .dout(dat_out));

  assign xfer_size = eff_size(size);
  assign xfer_dir  = dir;
endmodule

// File: tb/dma_chain_ctrl_test.sv
module dma_chain_ctrl_test;
  localparam int CLK_PER = 10;
  localparam int CW = 12;
  localparam int LN = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, abort = 1'b0, xfer_ack = 1'b0, desc_ack = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic xfer_req, xfer_dir, desc_req, irq;
  logic [1:0] xfer_size;
  logic [63:0] xfer_src, xfer_dst, desc_addr, desc_data = 64'd0;
  logic [LN*32-1:0] dat_in = '0, dat_out;

  int total = 0, bad = 0, nbeat = 0, ndesc = 0, nirq = 0;
  logic [63:0] first_da = 64'd0;
  bit hold_ack = 1'b0, done = 1'b0;

  // behavioural reference state
  bit m_crst, m_ie, m_dir, m_swap, m_act, m_chen, m_ff, m_abn, m_ncc, m_irq;
  int m_size, m_cnt, m_st, m_idx;
  logic [63:0] m_src, m_dst, m_chain;

  dma_chain_ctrl #(.CNT_W(CW), .LANES(LN)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .abort(abort), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
    .xfer_size(xfer_size), .xfer_dir(xfer_dir), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .dat_in(dat_in), .dat_out(dat_out), .desc_req(desc_req), .desc_ack(desc_ack),
    .desc_addr(desc_addr), .desc_data(desc_data), .irq(irq)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic int bytes_of(input int sz);
    return (sz == 1) ? 8 : (sz == 2) ? 32 : 4;
  endfunction

  function automatic logic [63:0] desc_word(input logic [63:0] a);
    case (a)
      64'h1000: return 64'h100;
      64'h1008: return 64'h800;
      64'h1010: return 64'd8;
      64'h1018: return 64'h2000;
      64'h2000: return 64'h300;
      64'h2008: return 64'h900;
      64'h2010: return 64'd4;
      default:  return 64'd0;
    endcase
  endfunction

  // reference model, advanced on every rising edge from the same inputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_crst = 1; m_ie = 0; m_dir = 0; m_swap = 0; m_act = 0; m_chen = 0; m_ff = 0;
      m_abn = 0; m_ncc = 0; m_irq = 0; m_size = 0; m_cnt = 0; m_st = 0; m_idx = 0;
      m_src = 0; m_dst = 0; m_chain = 0;
    end else begin
      int bb, nst, nidx;
      bit last, ev_b, ev_d, ev_fg, ev_ac, nirq_b, live;
      bit n_act, n_chen, n_ff;
      bb = bytes_of(m_size); last = (m_cnt <= bb);
      nst = m_st; nidx = m_idx; ev_b = 0; ev_d = 0; ev_fg = 0; ev_ac = 0; nirq_b = 0;
      if (m_st == 0 && m_act) begin
        if (m_ff || (m_cnt == 0 && m_chen)) begin nst = 2; nidx = 0; ev_fg = 1; end
        else if (m_cnt != 0) nst = 1;
        else ev_ac = 1;
      end else if (m_st == 1 && xfer_ack) begin
        ev_b = 1;
        if (last) begin
          nirq_b = m_ie;
          if (m_chen && m_act) begin nst = 2; nidx = 0; ev_fg = 1; end
          else begin nst = 0; ev_ac = 1; end
        end else if (!m_act) nst = 0;
      end else if (m_st == 2 && desc_ack) begin
        ev_d = 1; nidx = (m_idx + 1) % 4;
        if (m_idx == 3) nst = 0;
      end
      if (abort || m_crst) begin nst = 0; nidx = 0; nirq_b = 0; ev_b = 0; ev_d = 0; ev_fg = 0; ev_ac = 0; end
      live = !m_crst;
      n_act = m_act; n_chen = m_chen; n_ff = m_ff;
      if (reg_we && reg_sel == 0) begin
        if (!reg_wdata[5]) n_act = 0;
        else if (m_cnt != 0 || m_chen) n_act = 1;
      end
      if (live && reg_we && reg_sel == 2) begin
        n_chen = (reg_wdata != 0);
        if (reg_wdata != 0) begin n_act = 1; n_ff = 1; end
      end
      if (ev_ac || abort) n_act = 0;
      if (ev_fg && !(live && reg_we && reg_sel == 2 && reg_wdata != 0)) n_ff = 0;
      if (live && reg_we && reg_sel == 1) m_cnt = reg_wdata & ((1 << CW) - 1);
      if (live && reg_we && reg_sel == 2) m_chain[31:0] = reg_wdata;
      if (live && reg_we && reg_sel == 3) m_chain[63:32] = reg_wdata;
      if (live && reg_we && reg_sel == 4 && reg_wdata[0]) m_abn = 0;
      if (live && reg_we && reg_sel == 4 && reg_wdata[1]) m_ncc = 0;
      if (abort) m_abn = 1;
      if (ev_d) begin
        if (m_idx == 0) m_src = desc_data;
        else if (m_idx == 1) m_dst = desc_data;
        else if (m_idx == 2) m_cnt = int'(desc_data[CW-1:0]);
        else begin
          m_chain = desc_data; n_chen = (desc_data[31:0] != 0);
          if (desc_data[31:0] == 0) m_ncc = 1;
        end
      end
      if (ev_b) begin
        m_cnt = last ? 0 : m_cnt - bb;
        m_src = m_src + 64'(bb); m_dst = m_dst + 64'(bb);
      end
      m_act = n_act; m_chen = n_chen; m_ff = n_ff;
      if (m_crst) begin
        m_act = 0; m_chen = 0; m_ff = 0; m_abn = 0; m_ncc = 0;
        m_cnt = 0; m_src = 0; m_dst = 0; m_chain = 0;
      end
      if (reg_we && reg_sel == 0) begin
        m_ie = reg_wdata[8]; m_dir = reg_wdata[7]; m_size = int'(reg_wdata[3:2]);
        m_swap = reg_wdata[1]; m_crst = reg_wdata[0];
      end
      m_st = nst; m_idx = nidx; m_irq = nirq_b;
    end
  end

  // event counters seen at the ports
  always @(posedge clk) begin
    if (xfer_req && xfer_ack) nbeat++;
    if (irq) nirq++;
    if (desc_req && desc_ack) begin
      if (ndesc == 0) first_da = desc_addr;
      ndesc++;
    end
  end

  // per-cycle comparison of registered outputs (R3 R6 R7 R9 R11)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [63:0] exp_da;
      logic [1:0] exp_sz;
      bit ok;
      exp_da = m_chain + 64'(m_idx * 8);
      exp_sz = (m_size == 3) ? 2'b00 : 2'(m_size);
      ok = (xfer_req === (m_st == 1)) && (desc_req === (m_st == 2)) && (irq === m_irq) &&
           (xfer_src === m_src) && (xfer_dst === m_dst) && (xfer_size === exp_sz) &&
           (xfer_dir === m_dir) && (!desc_req || desc_addr === exp_da);
      total++;
      if (!ok) begin
        bad++;
        $display("FAIL R3 R6 R7 R9 R11 cycle: req=%b/%b dreq=%b/%b irq=%b/%b src=%h/%h dst=%h/%h da=%h/%h sz=%b/%b",
                 xfer_req, m_st == 1, desc_req, m_st == 2, irq, m_irq, xfer_src, m_src,
                 xfer_dst, m_dst, desc_addr, exp_da, xfer_size, exp_sz);
      end
    end
    xfer_ack  <= xfer_req && !hold_ack;
    desc_ack  <= desc_req;
    desc_data <= desc_word(desc_addr);
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_sel = s;
    #1 chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b0, i0, d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(0, 32'h001, "R1 cfg reset");
    rd(1, 32'h0, "R1 count reset");
    rd(2, 32'h0, "R1 chain low reset");
    rd(4, 32'h0, "R1 status reset");
    // R2 writes ignored while channel reset is held
    wr(1, 32'd16);
    rd(1, 32'h0, "R2 count held");
    wr(0, 32'h021);
    rd(0, 32'h001, "R2 active held");
    wr(0, 32'h000);
    // R5 start refused with nothing to do
    wr(0, 32'h020);
    rd(0, 32'h000, "R5 start ignored");
    // R6 R7 R3 plain transfer, 16 bytes of 4
    b0 = nbeat; i0 = nirq;
    wr(1, 32'd16); wr(0, 32'h120);
    repeat (12) @(negedge clk);
    chk("R6 beats", 64'(nbeat - b0), 64'd4);
    chk("R7 one irq", 64'(nirq - i0), 64'd1);
    rd(0, 32'h100, "R6 active cleared");
    rd(1, 32'h0, "R6 count zero");
    chk("R3 source advance", xfer_src, 64'd16);
    // R3 reserved size, 6 bytes saturates after two
    b0 = nbeat; i0 = nirq;
    wr(1, 32'd6); wr(0, 32'h02C);
    repeat (10) @(negedge clk);
    chk("R3 saturate beats", 64'(nbeat - b0), 64'd2);
    chk("R7 no irq when disabled", 64'(nirq - i0), 64'd0);
    chk("R3 reserved step", xfer_src, 64'd24);
    // R3 burst size
    b0 = nbeat;
    wr(1, 32'd64); wr(0, 32'h028);
    repeat (10) @(negedge clk);
    chk("R3 burst beats", 64'(nbeat - b0), 64'd2);
    chk("R3 burst step", xfer_dst, 64'd88);
    // R4 direction and swap
    wr(0, 32'h082);
    @(negedge clk); dat_in = 64'h11223344_55667788;
    #1 chk("R4 swapped", dat_out, 64'h44332211_88776655);
    chk("R4 direction", 64'(xfer_dir), 64'd1);
    wr(0, 32'h080);
    #1 chk("R4 unswapped", dat_out, 64'h11223344_55667788);
    // R8 upper half writes start nothing
    wr(0, 32'h180);
    wr(3, 32'h5);
    rd(0, 32'h180, "R8 upper write no flags");
    rd(3, 32'h5, "R8 upper stored");
    wr(3, 32'h0);
    wr(2, 32'h0);
    rd(0, 32'h180, "R8 zero low no start");
    // R8 R9 R10 two-descriptor chain
    b0 = nbeat; i0 = nirq; d0 = ndesc;
    wr(2, 32'h1000);
    repeat (40) @(negedge clk);
    chk("R8 first fetch address", first_da, 64'h1000);
    chk("R9 descriptor words", 64'(ndesc - d0), 64'd8);
    chk("R9 chained beats", 64'(nbeat - b0), 64'd3);
    chk("R7 irq per transfer", 64'(nirq - i0), 64'd2);
    chk("R9 final source", xfer_src, 64'h304);
    rd(0, 32'h180, "R9 idle after chain");
    rd(4, 32'h2, "R10 chain end flag");
    wr(4, 32'h2);
    rd(4, 32'h0, "R10 flag cleared");
    // R11 abort a stalled transfer
    hold_ack = 1'b1;
    wr(1, 32'd400); wr(0, 32'h020);
    repeat (3) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    hold_ack = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 request dropped", 64'(xfer_req), 64'd0);
    rd(0, 32'h000, "R11 active cleared");
    rd(4, 32'h1, "R11 abnormal flag");
    rd(1, 32'd400, "R11 count kept");
    wr(4, 32'h1);
    rd(4, 32'h0, "R11 flag cleared");
    // R12 software stop finishes one transaction
    b0 = nbeat;
    hold_ack = 1'b1;
    wr(1, 32'd40); wr(0, 32'h020);
    repeat (3) @(negedge clk);
    wr(0, 32'h000);
    hold_ack = 1'b0;
    repeat (6) @(negedge clk);
    chk("R12 one more beat", 64'(nbeat - b0), 64'd1);
    rd(1, 32'd36, "R12 remainder kept");
    chk("R12 stopped", 64'(xfer_req), 64'd0);
    // R2 setting channel reset clears state
    wr(0, 32'h001);
    rd(1, 32'h0, "R2 reset clears count");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule